// File: doc/BRIEF.md
# Register-Offset Load/Store Unit

This unit carries out one memory access whose address is a base register plus a second register shifted left by zero to three places. It receives an already decoded operation: direction, access size, the indices and values of the base and offset registers, the shift, the target register index, the data to store, and two flags that say whether the operation sits inside a conditional block and whether it is that block's final instruction. It drives a 32-bit little-endian memory through a valid/ready request and a one-cycle response strobe.

Before anything reaches memory, the unit checks the register choices and the alignment of the address. A rejected operation produces a fault and never appears on the memory port. A load returns its data aligned to bit 0 and extended to 32 bits, together with the index of the register to write. A word load into the program counter is not written back. The unit checks bit 0 of the loaded value: when it is set the unit issues a branch, and when it is clear the unit raises an execution fault.

The unit handles one operation at a time. It is ready only when idle. Every accepted operation, including one that faults, ends in exactly one single-cycle `done` pulse. The fault, branch and writeback outputs are meaningful only during that pulse.

Top module: `ldst_regoff_unit`

## Requirements
- R1: The memory address is `op_rn_val + (op_rm_val << op_shift)`, truncated to 32 bits.
- R2: Size codes on `op_size` are 0 unsigned byte, 1 signed byte, 2 unsigned halfword, 3 signed halfword, 4 word. Codes 5 to 7 are illegal.
- R3: A store asserts `mem_we` and drives data and byte enables as follows. A byte store repeats the byte in all four lanes and enables only lane `addr[1:0]`. A halfword store repeats the halfword twice and enables bytes {1,0} when `addr[1]` is 0 and {3,2} when it is 1. A word store enables 4'hF.
- R4: Unsigned byte and unsigned halfword loads take the lane selected by the address and zero-extend it. A word load returns the whole word.
- R5: Signed byte and signed halfword loads take the selected lane and sign-extend it.
- R6: A store with a signed size raises `fault_illegal` and makes no memory request.
- R7: A base index of 15, or an offset index of 13 or 15, raises `fault_illegal` and makes no memory request.
- R8: A target index of 13 is legal only for word loads and word stores. A target index of 15 is legal only for word loads. Any other use raises `fault_illegal` with no memory request.
- R9: A halfword access with `addr[0]` set, or a word access with `addr[1:0]` not zero, raises `fault_align` and makes no memory request. It does this only when no illegal fault applies.
- R10: A word load into index 15 whose value has bit 0 set pulses `branch_valid`, with `branch_target` equal to the value with bit 0 cleared, and asserts no writeback.
- R11: A word load into index 15 whose value has bit 0 clear raises `fault_exec`, with no branch and no writeback.
- R12: A word load into index 15 with `op_in_cond` set and `op_cond_last` clear raises `fault_illegal` with no memory request. With both flags set, the load proceeds.
- R13: `op_ready` is high only when idle. Each accepted operation gives one single-cycle `done`. A store completes in the cycle after its request is accepted, and a load completes in the cycle after `mem_rsp_valid`. A successful load to any index other than 15 asserts `done_wb` with `done_rt` and `done_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle and accepting |
| op_is_load | input | 1 | 1 load, 0 store |
| op_size | input | 3 | Access size code (R2) |
| op_rn_idx | input | 4 | Base register index |
| op_rn_val | input | 32 | Base register value |
| op_rm_idx | input | 4 | Offset register index |
| op_rm_val | input | 32 | Offset register value |
| op_shift | input | 2 | Left shift applied to the offset |
| op_rt_idx | input | 4 | Target register index |
| op_store_data | input | 32 | Data to store |
| op_in_cond | input | 1 | Operation is inside a conditional block |
| op_cond_last | input | 1 | Operation is the last of its conditional block |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_be | output | 4 | Byte enables |
| mem_rsp_valid | input | 1 | Load data valid |
| mem_rdata | input | 32 | Load data word |
| done | output | 1 | Operation complete (one cycle) |
| done_wb | output | 1 | Write `done_data` to `done_rt` |
| done_rt | output | 4 | Writeback register index |
| done_data | output | 32 | Aligned and extended load data |
| branch_valid | output | 1 | Branch request from a load into the program counter |
| branch_target | output | 32 | Branch address, bit 0 clear |
| fault_illegal | output | 1 | Forbidden register or size choice |
| fault_align | output | 1 | Misaligned access |
| fault_exec | output | 1 | Program-counter value with bit 0 clear |

## Verification
The checker assumes the memory asserts `mem_rsp_valid` only once per accepted load request, and only while the unit waits for that response. It also assumes a store never draws a response. From that assumption it derives that a response leads straight to `done`. The bench memory model answers every accepted read exactly one cycle later and never answers a write, so the stimulus stays inside this assumption. Request stalls of zero to two cycles exercise the part of the handshake where the request must be held.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

   typedef enum logic [2:0] {
      SZ_UB = 3'd0,
      SZ_SB = 3'd1,
      SZ_UH = 3'd2,
      SZ_SH = 3'd3,
      SZ_W  = 3'd4
   } acc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } ldst_state_e;

   function automatic logic size_is_half(input logic [2:0] s);
      return (s == SZ_UH) || (s == SZ_SH);
   endfunction

   function automatic logic size_is_byte(input logic [2:0] s);
      return (s == SZ_UB) || (s == SZ_SB);
   endfunction

   function automatic logic size_is_signed(input logic [2:0] s);
      return (s == SZ_SB) || (s == SZ_SH);
   endfunction

endpackage

// File: rtl/ldst_agu.sv
module ldst_agu
   import ldst_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int SHIFT_W = 2
) (
   input  logic [XLEN-1:0]    base_val,
   input  logic [XLEN-1:0]    off_val,
   input  logic [SHIFT_W-1:0] shift,
   input  logic [2:0]         size,
   output logic [XLEN-1:0]    ea,
   output logic               misaligned
);
   always_comb begin
      ea         = base_val + (off_val << shift);
      misaligned = (size_is_half(size) && ea[0]) ||
                   ((size == SZ_W) && (ea[1:0] != 2'b00));
   end
endmodule

// File: rtl/ldst_rules.sv
module ldst_rules
   import ldst_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int SP_IDX = 13,
   parameter int PC_IDX = 15
) (
   input  logic             is_load,
   input  logic [2:0]       size,
   input  logic [IDX_W-1:0] rn_idx,
   input  logic [IDX_W-1:0] rm_idx,
   input  logic [IDX_W-1:0] rt_idx,
   input  logic             in_cond,
   input  logic             cond_last,
   output logic             illegal,
   output logic             pc_load
);
   localparam logic [IDX_W-1:0] SP = IDX_W'(SP_IDX);
   localparam logic [IDX_W-1:0] PC = IDX_W'(PC_IDX);

   logic word, bad_size, bad_base, bad_off, bad_rt, bad_cond;

   always_comb begin
      word     = (size == SZ_W);
      pc_load  = is_load && word && (rt_idx == PC);
      bad_size = (size > SZ_W) || (!is_load && size_is_signed(size));
      bad_base = (rn_idx == PC);
      bad_off  = (rm_idx == SP) || (rm_idx == PC);
      bad_rt   = ((rt_idx == SP) && !word) ||
                 ((rt_idx == PC) && !(is_load && word));
      bad_cond = pc_load && in_cond && !cond_last;
      illegal  = bad_size || bad_base || bad_off || bad_rt || bad_cond;
   end
endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
   import ldst_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [2:0]          size,
   input  logic [XLEN-1:0]     addr,
   input  logic [XLEN-1:0]     sdata,
   output logic [XLEN/8-1:0]   be,
   output logic [XLEN-1:0]     wdata
);
   localparam int LANES  = XLEN / 8;
   localparam int LANE_W = $clog2(LANES);

   always_comb begin
      if (size_is_byte(size))      wdata = {LANES{sdata[7:0]}};
      else if (size_is_half(size)) wdata = {(LANES/2){sdata[15:0]}};
      else                         wdata = sdata;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [LANE_W-1:0] LID = LANE_W'(i);
      assign be[i] = (size == SZ_W) ||
                     (size_is_half(size) && (addr[LANE_W-1:1] == LID[LANE_W-1:1])) ||
                     (size_is_byte(size) && (addr[LANE_W-1:0] == LID));
   end
endmodule

// File: rtl/ldst_load_extend.sv
module ldst_load_extend
   import ldst_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [2:0]      size,
   input  logic [1:0]      lane,
   input  logic [XLEN-1:0] rdata,
   output logic [XLEN-1:0] ext
);
   logic [XLEN-1:0] sh_b, sh_h;

   always_comb begin
      sh_b = rdata >> {lane, 3'b000};
      sh_h = rdata >> {lane[1], 4'b0000};
      case (size)
         SZ_UB:   ext = {{(XLEN-8){1'b0}}, sh_b[7:0]};
         SZ_SB:   ext = {{(XLEN-8){sh_b[7]}}, sh_b[7:0]};
         SZ_UH:   ext = {{(XLEN-16){1'b0}}, sh_h[15:0]};
         SZ_SH:   ext = {{(XLEN-16){sh_h[15]}}, sh_h[15:0]};
         default: ext = rdata;
      endcase
   end
endmodule

// File: rtl/ldst_regoff_unit.sv
module ldst_regoff_unit
   import ldst_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int IDX_W     = 4,
   parameter int SP_IDX    = 13,
   parameter int PC_IDX    = 15,
   parameter int MAX_SHIFT = 3,
   localparam int SHIFT_W  = $clog2(MAX_SHIFT + 1),
   localparam int BE_W     = XLEN / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   output logic               op_ready,
   input  logic               op_is_load,
   input  logic [2:0]         op_size,
   input  logic [IDX_W-1:0]   op_rn_idx,
   input  logic [XLEN-1:0]    op_rn_val,
   input  logic [IDX_W-1:0]   op_rm_idx,
   input  logic [XLEN-1:0]    op_rm_val,
   input  logic [SHIFT_W-1:0] op_shift,
   input  logic [IDX_W-1:0]   op_rt_idx,
   input  logic [XLEN-1:0]    op_store_data,
   input  logic               op_in_cond,
   input  logic               op_cond_last,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic               mem_we,
   output logic [XLEN-1:0]    mem_addr,
   output logic [XLEN-1:0]    mem_wdata,
   output logic [BE_W-1:0]    mem_be,
   input  logic               mem_rsp_valid,
   input  logic [XLEN-1:0]    mem_rdata,
   output logic               done,
   output logic               done_wb,
   output logic [IDX_W-1:0]   done_rt,
   output logic [XLEN-1:0]    done_data,
   output logic               branch_valid,
   output logic [XLEN-1:0]    branch_target,
   output logic               fault_illegal,
   output logic               fault_align,
   output logic               fault_exec
);
   if (XLEN != 32) begin : g_bad_xlen
      $error("ldst_regoff_unit: XLEN must be 32");
   end
   if (MAX_SHIFT != (1 << SHIFT_W) - 1) begin : g_bad_shift
      $error("ldst_regoff_unit: MAX_SHIFT must be a power of two minus one");
   end
   if (SP_IDX >= (1 << IDX_W) || PC_IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("ldst_regoff_unit: special register index out of range");
   end

   logic [XLEN-1:0] ea, lane_wdata, ext;
   logic [BE_W-1:0] lane_be;
   logic            misaligned, illegal, pc_load;

   ldst_agu #(.XLEN(XLEN), .SHIFT_W(SHIFT_W)) u_agu (
      .base_val(op_rn_val), .off_val(op_rm_val), .shift(op_shift),
      .size(op_size), .ea(ea), .misaligned(misaligned)
   );

   ldst_rules #(.IDX_W(IDX_W), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_rules (
      .is_load(op_is_load), .size(op_size), .rn_idx(op_rn_idx),
      .rm_idx(op_rm_idx), .rt_idx(op_rt_idx), .in_cond(op_in_cond),
      .cond_last(op_cond_last), .illegal(illegal), .pc_load(pc_load)
   );

   ldst_store_lanes #(.XLEN(XLEN)) u_lanes (
      .size(op_size), .addr(ea), .sdata(op_store_data),
      .be(lane_be), .wdata(lane_wdata)
   );

   ldst_state_e      state;
   logic             r_load, r_ill, r_al, r_pc;
   logic [2:0]       r_size;
   logic [IDX_W-1:0] r_rt;
   logic [XLEN-1:0]  r_addr, r_wdata, r_rdata;
   logic [BE_W-1:0]  r_be;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         r_load  <= 1'b0;
         r_ill   <= 1'b0;
         r_al    <= 1'b0;
         r_pc    <= 1'b0;
         r_size  <= '0;
         r_rt    <= '0;
         r_addr  <= '0;
         r_wdata <= '0;
         r_rdata <= '0;
         r_be    <= '0;
      end else begin
         case (state)
            ST_IDLE: if (op_valid) begin
               r_load  <= op_is_load;
               r_size  <= op_size;
               r_rt    <= op_rt_idx;
               r_addr  <= ea;
               r_wdata <= lane_wdata;
               r_be    <= lane_be;
               r_pc    <= pc_load;
               r_ill   <= illegal;
               r_al    <= !illegal && misaligned;
               r_rdata <= '0;
               state   <= (illegal || misaligned) ? ST_DONE : ST_REQ;
            end
            ST_REQ: if (mem_req_ready) state <= r_load ? ST_WAIT : ST_DONE;
            ST_WAIT: if (mem_rsp_valid) begin
               r_rdata <= mem_rdata;
               state   <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   ldst_load_extend #(.XLEN(XLEN)) u_ext (
      .size(r_size), .lane(r_addr[1:0]), .rdata(r_rdata), .ext(ext)
   );

   logic ok_load;

   always_comb begin
      op_ready      = (state == ST_IDLE);
      mem_req_valid = (state == ST_REQ);
      mem_we        = !r_load;
      mem_addr      = r_addr;
      mem_wdata     = r_wdata;
      mem_be        = r_be;
      done          = (state == ST_DONE);
      ok_load       = done && r_load && !r_ill && !r_al;
      done_wb       = ok_load && !r_pc;
      done_rt       = r_rt;
      done_data     = ext;
      branch_valid  = ok_load && r_pc && r_rdata[0];
      branch_target = {r_rdata[XLEN-1:1], 1'b0};
      fault_exec    = ok_load && r_pc && !r_rdata[0];
      fault_illegal = done && r_ill;
      fault_align   = done && r_al;
   end
endmodule

// File: rtl/ldst_regoff_chk.sv
module ldst_regoff_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        op_valid,
   input logic        op_ready,
   input logic        mem_req_valid,
   input logic        mem_req_ready,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [3:0]  mem_be,
   input logic        mem_rsp_valid,
   input logic        done,
   input logic        done_wb,
   input logic        branch_valid,
   input logic [31:0] branch_target,
   input logic        fault_illegal,
   input logic        fault_align,
   input logic        fault_exec
);
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R13
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_ready |=> !op_ready); // R13
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_be)); // R13
   AST_REQ_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !op_ready && !done); // R13
   AST_STORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready && mem_we |=> done); // R13
   AST_RSP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid && !op_ready && !mem_req_valid && !done |=> done); // R13
   AST_OUTCOME_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $countones({done_wb, branch_valid, fault_illegal, fault_align, fault_exec}) <= 1); // R11
   AST_OUTCOME_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_wb || branch_valid || fault_illegal || fault_align || fault_exec) |-> done); // R13
   AST_BRANCH_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      branch_valid |-> !branch_target[0]); // R10
   AST_BE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_be != 4'h0); // R3
   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_be == 4'hF |-> mem_addr[1:0] == 2'b00); // R9
endmodule

bind ldst_regoff_unit ldst_regoff_chk u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
   .mem_rsp_valid(mem_rsp_valid), .done(done), .done_wb(done_wb),
   .branch_valid(branch_valid), .branch_target(branch_target),
   .fault_illegal(fault_illegal), .fault_align(fault_align),
   .fault_exec(fault_exec)
);

// File: tb/sim_ldst_regoff_unit.sv
module sim_ldst_regoff_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0, op_ready, op_is_load = 1'b0;
   logic [2:0]  op_size = '0;
   logic [3:0]  op_rn_idx = '0, op_rm_idx = '0, op_rt_idx = '0;
   logic [31:0] op_rn_val = '0, op_rm_val = '0, op_store_data = '0;
   logic [1:0]  op_shift = '0;
   logic        op_in_cond = 1'b0, op_cond_last = 1'b0;
   logic        mem_req_valid, mem_req_ready, mem_we, mem_rsp_valid = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic [3:0]  mem_be;
   logic        done, done_wb, branch_valid, fault_illegal, fault_align, fault_exec;
   logic [3:0]  done_rt;
   logic [31:0] done_data, branch_target;

   always #5 clk = ~clk;

   ldst_regoff_unit u0 (.*);

   // memory model: 16 words, one-cycle read response, optional request stall
   logic [31:0] bmem [16];
   logic [1:0]  stall_cfg = '0, stall_left = '0;
   int          hs_cnt = 0;
   logic [31:0] last_addr = '0, last_wdata = '0;
   logic [3:0]  last_be = '0;
   assign mem_req_ready = (stall_left == 2'd0);

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (!mem_req_valid) stall_left <= stall_cfg;
      else if (stall_left != 2'd0) stall_left <= stall_left - 2'd1;
      if (mem_req_valid && mem_req_ready) begin
         hs_cnt     <= hs_cnt + 1;
         last_addr  <= mem_addr;
         last_be    <= mem_be;
         last_wdata <= mem_wdata;
         if (mem_we) begin
            for (int i = 0; i < 4; i++)
               if (mem_be[i]) bmem[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
         end else begin
            mem_rsp_valid <= 1'b1;
            mem_rdata     <= bmem[mem_addr[5:2]];
         end
      end
   end

   int n_chk = 0, n_err = 0;
   logic g_done, g_wb, g_br, g_ill, g_al, g_ex, g_busy;
   logic [3:0]  g_rt;
   logic [31:0] g_data, g_tgt;
   int          g_hs;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic ld, input logic [2:0] sz,
                         input logic [3:0] rn, input logic [31:0] rnv,
                         input logic [3:0] rm, input logic [31:0] rmv,
                         input logic [1:0] sh, input logic [3:0] rt,
                         input logic [31:0] sd, input logic ic, input logic last,
                         input logic [1:0] stall);
      int hs0;
      @(negedge clk);
      stall_cfg = stall;
      op_is_load = ld; op_size = sz; op_rn_idx = rn; op_rn_val = rnv;
      op_rm_idx = rm; op_rm_val = rmv; op_shift = sh; op_rt_idx = rt;
      op_store_data = sd; op_in_cond = ic; op_cond_last = last;
      op_valid = 1'b1;
      hs0 = hs_cnt;
      @(negedge clk);
      op_valid = 1'b0;
      g_busy = !op_ready;
      for (int k = 0; k < 30 && !done; k++) @(negedge clk);
      g_done = done; g_wb = done_wb; g_br = branch_valid; g_ill = fault_illegal;
      g_al = fault_align; g_ex = fault_exec; g_rt = done_rt; g_data = done_data;
      g_tgt = branch_target;
      @(negedge clk);
      g_hs = hs_cnt - hs0;
   endtask

   task automatic load_ok(input string tag, input logic [2:0] sz, input logic [31:0] addr,
                          input logic [3:0] rt, input logic [31:0] exp);
      run_op(1'b1, sz, 4'd1, addr, 4'd2, 32'd0, 2'd0, rt, 32'd0, 1'b0, 1'b0, 2'd0);
      chk({tag, " done"}, {31'd0, g_done}, 32'd1);
      chk({tag, " wb"}, {31'd0, g_wb}, 32'd1);
      chk({tag, " rt"}, {28'd0, g_rt}, {28'd0, rt});
      chk({tag, " data"}, g_data, exp);
   endtask

   task automatic expect_fault(input string tag, input logic ill, input logic al,
                               input logic ld, input logic [2:0] sz,
                               input logic [3:0] rn, input logic [31:0] rnv,
                               input logic [3:0] rm, input logic [3:0] rt,
                               input logic ic, input logic last);
      run_op(ld, sz, rn, rnv, rm, 32'd0, 2'd0, rt, 32'h1234_5678, ic, last, 2'd0);
      chk({tag, " done"}, {31'd0, g_done}, 32'd1);
      chk({tag, " faults"}, {30'd0, g_ill, g_al}, {30'd0, ill, al});
      chk({tag, " no mem access"}, g_hs, 32'd0);
      chk({tag, " no wb"}, {31'd0, g_wb}, 32'd0);
   endtask

   task automatic t_reset();
      chk("R13 reset op_ready", {31'd0, op_ready}, 32'd1);
      chk("R13 reset done", {31'd0, done}, 32'd0);
      chk("R13 reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
   endtask

   task automatic t_stores();
      // R1 word store at 0x100 + (4<<2) = 0x110, with a two-cycle stall
      run_op(1'b0, 3'd4, 4'd1, 32'h100, 4'd2, 32'd4, 2'd2, 4'd3, 32'hA1B2C3D4, 1'b0, 1'b0, 2'd2);
      chk("R13 busy after accept", {31'd0, g_busy}, 32'd1);
      chk("R1 store address", last_addr, 32'h110);
      chk("R3 word be", {28'd0, last_be}, 32'hF);
      chk("R3 word stored", bmem[4], 32'hA1B2C3D4);
      chk("R13 store no wb", {31'd0, g_wb}, 32'd0);
      chk("R13 store one access", g_hs, 32'd1);
      // R3 byte store to 0x23
      run_op(1'b0, 3'd0, 4'd1, 32'h20, 4'd2, 32'd3, 2'd0, 4'd3, 32'h0000005A, 1'b0, 1'b0, 2'd0);
      chk("R3 byte be", {28'd0, last_be}, 32'h8);
      chk("R3 byte wdata", last_wdata, 32'h5A5A5A5A);
      chk("R3 byte stored", bmem[8], 32'h5A000000);
      // R3 halfword store to 0x40 + (1<<1) = 0x42
      run_op(1'b0, 3'd2, 4'd1, 32'h40, 4'd2, 32'd1, 2'd1, 4'd3, 32'h0000BEEF, 1'b0, 1'b0, 2'd1);
      chk("R3 half be", {28'd0, last_be}, 32'hC);
      chk("R3 half wdata", last_wdata, 32'hBEEFBEEF);
      chk("R1 half address", last_addr, 32'h42);
   endtask

   task automatic t_loads();
      load_ok("R4 ub lane3", 3'd0, 32'h07, 4'd5, 32'h00000080);
      load_ok("R5 sb lane3", 3'd1, 32'h07, 4'd5, 32'hFFFFFF80);
      load_ok("R5 sb lane0", 3'd1, 32'h04, 4'd6, 32'h00000022);
      load_ok("R4 uh upper", 3'd2, 32'h06, 4'd7, 32'h000080F1);
      load_ok("R5 sh upper", 3'd3, 32'h06, 4'd7, 32'hFFFF80F1);
      load_ok("R5 sh lower", 3'd3, 32'h04, 4'd0, 32'h00007F22);
      load_ok("R4 word", 3'd4, 32'h04, 4'd3, 32'h80F17F22);
      load_ok("R8 sp word load", 3'd4, 32'h04, 4'd13, 32'h80F17F22);
   endtask

   task automatic t_illegal();
      expect_fault("R6 signed store", 1'b1, 1'b0, 1'b0, 3'd1, 4'd1, 32'h0, 4'd2, 4'd3, 1'b0, 1'b0);
      expect_fault("R2 bad size code", 1'b1, 1'b0, 1'b1, 3'd6, 4'd1, 32'h0, 4'd2, 4'd3, 1'b0, 1'b0);
      expect_fault("R7 base pc", 1'b1, 1'b0, 1'b1, 3'd4, 4'd15, 32'h0, 4'd2, 4'd3, 1'b0, 1'b0);
      expect_fault("R7 offset sp", 1'b1, 1'b0, 1'b1, 3'd4, 4'd1, 32'h0, 4'd13, 4'd3, 1'b0, 1'b0);
      expect_fault("R7 offset pc", 1'b1, 1'b0, 1'b1, 3'd4, 4'd1, 32'h0, 4'd15, 4'd3, 1'b0, 1'b0);
      expect_fault("R8 sp byte load", 1'b1, 1'b0, 1'b1, 3'd0, 4'd1, 32'h0, 4'd2, 4'd13, 1'b0, 1'b0);
      expect_fault("R8 pc word store", 1'b1, 1'b0, 1'b0, 3'd4, 4'd1, 32'h0, 4'd2, 4'd15, 1'b0, 1'b0);
      expect_fault("R8 pc half load", 1'b1, 1'b0, 1'b1, 3'd2, 4'd1, 32'h0, 4'd2, 4'd15, 1'b0, 1'b0);
      expect_fault("R12 pc load not last", 1'b1, 1'b0, 1'b1, 3'd4, 4'd1, 32'h8, 4'd2, 4'd15, 1'b1, 1'b0);
      expect_fault("R9 half odd", 1'b0, 1'b1, 1'b1, 3'd2, 4'd1, 32'h5, 4'd2, 4'd3, 1'b0, 1'b0);
      expect_fault("R9 word half-aligned", 1'b0, 1'b1, 1'b0, 3'd4, 4'd1, 32'h6, 4'd2, 4'd3, 1'b0, 1'b0);
      // R8 word store from sp is legal
      run_op(1'b0, 3'd4, 4'd1, 32'h30, 4'd2, 32'd0, 2'd0, 4'd13, 32'h0BADF00D, 1'b0, 1'b0, 2'd0);
      chk("R8 sp word store legal", {30'd0, g_ill, g_al}, 32'd0);
      chk("R8 sp word store stored", bmem[12], 32'h0BADF00D);
   endtask

   task automatic t_pc_loads();
      run_op(1'b1, 3'd4, 4'd1, 32'h08, 4'd2, 32'd0, 2'd0, 4'd15, 32'd0, 1'b1, 1'b1, 2'd1);
      chk("R10 branch valid", {31'd0, g_br}, 32'd1);
      chk("R10 branch target", g_tgt, 32'h00001234);
      chk("R10 no wb", {31'd0, g_wb}, 32'd0);
      chk("R12 last in block allowed", {31'd0, g_ill}, 32'd0);
      run_op(1'b1, 3'd4, 4'd1, 32'h0C, 4'd2, 32'd0, 2'd0, 4'd15, 32'd0, 1'b0, 1'b0, 2'd0);
      chk("R11 exec fault", {31'd0, g_ex}, 32'd1);
      chk("R11 no branch", {31'd0, g_br}, 32'd0);
      chk("R11 no wb", {31'd0, g_wb}, 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) bmem[i] = 32'd0;
      bmem[1] = 32'h80F17F22;
      bmem[2] = 32'h00001235;
      bmem[3] = 32'h00002000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_stores();
      t_loads();
      t_illegal();
      t_pc_loads();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule